// File: doc/BRIEF.md
# Circular Trace-Buffer Write Pointer

This block keeps the write pointer of a branch-trace record buffer whose depth is chosen at run time. The pointer always names the buffer slot that the next recorded control transfer will fill. Each recorded transfer marks that slot valid and moves the pointer forward one step, wrapping at the selected depth.

When return-stack emulation is switched on, a qualified return moves the pointer back one step instead. This pops the newest call entry and marks its slot invalid. A frozen flag stops all recording. Software can write that flag, and a breakpoint can set it when freeze-on-breakpoint is enabled. A clear command invalidates every slot, so that shrinking the depth leaves no stale state in the slots above the new depth. Software may also load the pointer directly.

Top module: `trace_wrptr`

## Requirements
- R1: After reset the pointer reads 0, frozen reads 0 and every valid bit is 0.
- R2: A recorded transfer (`rec_i`) sets the valid bit of the slot the pointer names. On the next cycle the pointer reads one more.
- R3: When a transfer is recorded while the pointer equals depth−1, the pointer wraps to 0.
- R4: With `emu_i`=1, a qualified return (`ret_i`) moves the pointer back by one and clears the valid bit of the slot it now names. With `emu_i`=0, `ret_i` has no effect.
- R5: A return popped while the pointer is 0 moves the pointer to depth−1.
- R6: `depth_sel_i` sets the depth to 16·2^code for codes 0..4, and any larger code means 256. Bits of `ptr_o` at or above log2(depth) always read 0, including right after the depth shrinks.
- R7: While frozen reads 1, `rec_i` and `ret_i` move neither the pointer nor any valid bit.
- R8: `brk_i` sets frozen on the next cycle only when `frz_on_brk_i`=1. A transfer recorded in the same cycle as the breakpoint is still recorded.
- R9: `clr_i` clears all valid bits and leaves the pointer as it was. A transfer or return in the same cycle is ignored.
- R10: `ptr_wr_i` loads `ptr_wdata_i` masked to the bits valid for the current depth. It wins over any transfer or return in that cycle.
- R11: `frz_wr_i` loads frozen from `frz_wdata_i`. An enabled breakpoint in the same cycle wins and leaves frozen at 1.
- R12: With `emu_i`=1, a return and a transfer in the same cycle perform the pop only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_i | input | 1 | Transfer recorded this cycle |
| ret_i | input | 1 | Qualified return this cycle |
| emu_i | input | 1 | Return-stack emulation enable |
| depth_sel_i | input | 3 | Depth code (0:16 … 4:256) |
| clr_i | input | 1 | Invalidate all slots |
| frz_on_brk_i | input | 1 | Freeze on breakpoint enable |
| brk_i | input | 1 | Breakpoint event |
| frz_wr_i | input | 1 | Software write of frozen |
| frz_wdata_i | input | 1 | Value for frozen write |
| ptr_wr_i | input | 1 | Software write of pointer |
| ptr_wdata_i | input | 8 | Value for pointer write |
| ptr_o | output | 8 | Next slot to be written, masked to depth |
| frozen_o | output | 1 | Frozen status |
| valid_o | output | 256 | Per-slot valid bits |

## Verification
The collision of most interest is a breakpoint that arrives in the same cycle as a recorded transfer. Freezing is registered, so that transfer must still land and only later ones are blocked. The bench drives `brk_i` and `rec_i` together with the freeze enable set. It then expects the slot to be valid, the pointer advanced and frozen risen, and it checks that a transfer on the following cycle changes nothing. Two further collisions are judged the same way against a queued reference: return with transfer under emulation, and breakpoint with a software write of frozen.

// File: rtl/trace_wrptr.sv
module trace_wrptr #(
  parameter int PTR_W   = 8,
  parameter int LOG_MIN = 4,
  parameter int SEL_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rec_i,
  input  logic                    ret_i,
  input  logic                    emu_i,
  input  logic [SEL_W-1:0]        depth_sel_i,
  input  logic                    clr_i,
  input  logic                    frz_on_brk_i,
  input  logic                    brk_i,
  input  logic                    frz_wr_i,
  input  logic                    frz_wdata_i,
  input  logic                    ptr_wr_i,
  input  logic [PTR_W-1:0]        ptr_wdata_i,
  output logic [PTR_W-1:0]        ptr_o,
  output logic                    frozen_o,
  output logic [(1<<PTR_W)-1:0]   valid_o
);
  localparam int ENTRIES = 1 << PTR_W;
  localparam int MAX_SEL = PTR_W - LOG_MIN;

  logic [PTR_W-1:0]   ptr_q, mask, pm, inc, dec;
  logic [PTR_W:0]     span;
  logic [ENTRIES-1:0] valid_q;
  logic               frozen_q, live, pop_go, rec_go;
  int                 lg;

  always_comb begin
    lg   = LOG_MIN + ((int'(depth_sel_i) > MAX_SEL) ? MAX_SEL : int'(depth_sel_i));
    span = ((PTR_W+1)'(1) << lg) - (PTR_W+1)'(1);
    mask = span[PTR_W-1:0];
  end

  assign pm  = ptr_q & mask;
  assign inc = (pm == mask) ? '0 : pm + 1'b1;
  assign dec = (pm == '0) ? mask : pm - 1'b1;

  assign live   = !frozen_q && !clr_i && !ptr_wr_i;
  assign pop_go = live && emu_i && ret_i;
  assign rec_go = live && rec_i && !pop_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      frozen_q <= 1'b0;
      valid_q  <= '0;
    end else begin
      if (ptr_wr_i)    ptr_q <= ptr_wdata_i & mask;
      else if (pop_go) ptr_q <= dec;
      else if (rec_go) ptr_q <= inc;

      if (frz_on_brk_i && brk_i) frozen_q <= 1'b1;
      else if (frz_wr_i)         frozen_q <= frz_wdata_i;

      if (clr_i)       valid_q      <= '0;
      else if (pop_go) valid_q[dec] <= 1'b0;
      else if (rec_go) valid_q[pm]  <= 1'b1;
    end
  end

  assign ptr_o    = ptr_q & mask;
  assign frozen_o = frozen_q;
  assign valid_o  = valid_q;

  a_r2_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
    rec_go |=> valid_q[$past(pm)]);
  a_r4_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |=> !valid_q[ptr_q]);
  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !ptr_wr_i && !clr_i) |=> (ptr_q == $past(ptr_q)) && $stable(valid_q));
  a_r8_brk_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_on_brk_i && brk_i) |=> frozen_q);
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_q == '0));
  a_r10_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_i |=> ptr_q == ($past(ptr_wdata_i) & $past(mask)));
endmodule

// File: tb/sim_trace_wrptr.sv
module sim_trace_wrptr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec, ret, emu, clr, fen, brk, fwr, fwd, pwr;
  logic [2:0]   dsel;
  logic [7:0]   pwd;
  logic [7:0]   ptr_o;
  logic         frozen_o;
  logic [255:0] valid_o;

  logic [7:0]   m_ptr;
  logic         m_frz;
  logic [255:0] m_val;

  logic [7:0]   q_ptr[$];
  logic         q_frz[$];
  logic [255:0] q_val[$];
  string        q_tag[$];

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trace_wrptr u0 (
    .clk(clk), .rst_n(rst_n), .rec_i(rec), .ret_i(ret), .emu_i(emu),
    .depth_sel_i(dsel), .clr_i(clr), .frz_on_brk_i(fen), .brk_i(brk),
    .frz_wr_i(fwr), .frz_wdata_i(fwd), .ptr_wr_i(pwr), .ptr_wdata_i(pwd),
    .ptr_o(ptr_o), .frozen_o(frozen_o), .valid_o(valid_o)
  );

  function automatic logic [7:0] dmask(input logic [2:0] s);
    int c = (s > 3'd4) ? 4 : int'(s);
    return 8'((16 << c) - 1);
  endfunction

  task automatic step(input logic a_rec, a_ret, a_emu, input logic [2:0] a_dsel,
                      input logic a_clr, a_fen, a_brk, a_fwr, a_fwd, a_pwr,
                      input logic [7:0] a_pwd, input string tag);
    logic [7:0] mk, cur, nx;
    logic ok, pop, rc;
    @(negedge clk);
    rec = a_rec; ret = a_ret; emu = a_emu; dsel = a_dsel; clr = a_clr;
    fen = a_fen; brk = a_brk; fwr = a_fwr; fwd = a_fwd; pwr = a_pwr; pwd = a_pwd;
    mk  = dmask(a_dsel);
    cur = m_ptr & mk;
    ok  = !m_frz && !a_clr && !a_pwr;
    pop = ok && a_emu && a_ret;
    rc  = ok && a_rec && !pop;
    nx  = (cur == 8'd0) ? mk : cur - 8'd1;
    if (a_clr) m_val = '0;
    else if (pop) m_val[nx] = 1'b0;
    else if (rc) m_val[cur] = 1'b1;
    if (a_pwr) m_ptr = a_pwd & mk;
    else if (pop) m_ptr = nx;
    else if (rc) m_ptr = (cur == mk) ? 8'd0 : cur + 8'd1;
    if (a_fen && a_brk) m_frz = 1'b1;
    else if (a_fwr) m_frz = a_fwd;
    q_ptr.push_back(m_ptr & mk);
    q_frz.push_back(m_frz);
    q_val.push_back(m_val);
    q_tag.push_back(tag);
  endtask

  task automatic rec1(input logic [2:0] d, input string tag);
    step(1,0,0,d,0,0,0,0,0,0,8'd0,tag);
  endtask
  task automatic pop1(input logic [2:0] d, input string tag);
    step(0,1,1,d,0,0,0,0,0,0,8'd0,tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_ptr.size() > 0) begin
        logic [7:0] ep; logic ef; logic [255:0] ev; string t;
        ep = q_ptr.pop_front(); ef = q_frz.pop_front();
        ev = q_val.pop_front(); t = q_tag.pop_front();
        n_run++;
        if (ptr_o !== ep || frozen_o !== ef || valid_o !== ev) begin
          n_fail++;
          $display("FAIL %s: ptr=%0d frz=%0b val=%h expected ptr=%0d frz=%0b val=%h",
                   t, ptr_o, frozen_o, valid_o, ep, ef, ev);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rec = 0; ret = 0; emu = 0; dsel = 0; clr = 0; fen = 0; brk = 0;
    fwr = 0; fwd = 0; pwr = 0; pwd = 0;
    m_ptr = 0; m_frz = 0; m_val = '0;
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (ptr_o !== 8'd0 || frozen_o !== 1'b0 || valid_o !== '0) begin
      n_fail++;
      $display("FAIL R1: ptr=%0d frz=%0b val=%h expected 0 0 0", ptr_o, frozen_o, valid_o);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) rec1(3'd0, "R2 record advance");
    rec1(3'd0, "R3 wrap at depth-1");
    rec1(3'd0, "R2 record after wrap");
    pop1(3'd0, "R4 pop");
    pop1(3'd0, "R5 pop wrap from 0");
    pop1(3'd0, "R4 second pop");
    step(0,1,0,3'd0,0,0,0,0,0,0,8'd0,"R4 return ignored without emulation");
    step(1,1,1,3'd0,0,0,0,0,0,0,8'd0,"R12 return and record together");

    step(0,0,0,3'd0,0,0,0,0,0,1,8'hFF,"R10 load masked to depth 16");
    step(1,1,1,3'd4,0,0,0,0,0,1,8'hAB,"R10 load wins over movement");
    step(0,0,0,3'd1,0,0,0,0,0,0,8'd0,"R6 high bits masked after shrink");
    rec1(3'd1, "R6 record at depth 32");
    step(0,0,0,3'd6,0,0,0,0,0,1,8'hF0,"R6 large code means 256");
    rec1(3'd7, "R6 record at depth 256");
    step(0,0,0,3'd2,0,0,0,0,0,1,8'd63,"R6 load 63 at depth 64");
    rec1(3'd2, "R3 wrap at depth 64");

    step(0,0,0,3'd0,0,0,0,1,1,0,8'd0,"R11 software freeze");
    rec1(3'd0, "R7 record ignored while frozen");
    pop1(3'd0, "R7 pop ignored while frozen");
    step(0,0,0,3'd0,0,0,0,1,0,0,8'd0,"R11 software unfreeze");
    step(1,0,0,3'd0,0,0,1,0,0,0,8'd0,"R8 breakpoint without enable");
    step(1,0,0,3'd0,0,1,1,0,0,0,8'd0,"R8 breakpoint and record same cycle");
    rec1(3'd0, "R8 record after breakpoint freeze");
    step(0,0,0,3'd0,0,1,1,1,0,0,8'd0,"R11 breakpoint wins over unfreeze");
    step(0,0,0,3'd0,0,0,0,1,0,0,8'd0,"R11 unfreeze");

    for (int i = 0; i < 5; i++) rec1(3'd4, "R2 fill before clear");
    step(1,0,0,3'd4,1,0,0,0,0,0,8'd0,"R9 clear ignores record");
    rec1(3'd0, "R9 record after clear");

    @(negedge clk);
    rec = 0; ret = 0; pwr = 0; fwr = 0; brk = 0; clr = 0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule